// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block sits between eight external interrupt pins and the request bits of the maskable interrupt groups they feed (groups 23 to 30). Each pin carries a 2-bit trigger mode that decides whether a low level, a high level, a rising transition or a falling transition raises a request. For every pin the block brings the asynchronous input into the clock domain, evaluates it against its mode, and emits a single-cycle set-request pulse toward the group's request bit. Storing, clearing and arbitrating those requests is done elsewhere.

The modes live in two byte-wide configuration registers, four pins per byte, read and written through a simple synchronous write / combinational read port. Each pin runs a small state machine with three states: `PIN_WARMUP` (after reset, while the synchronizer and the previous-value register fill), `PIN_RUN` (normal evaluation) and `PIN_SETTLE` (one cycle after its mode byte is written, when edge detection is muted). Transitions: `PIN_WARMUP -> PIN_RUN` once the warm-up counter reaches the synchronizer depth; `PIN_RUN -> PIN_SETTLE` on a write to the pin's byte; `PIN_SETTLE -> PIN_SETTLE` on a further write; `PIN_SETTLE -> PIN_RUN` otherwise. A write during `PIN_WARMUP` does not leave that state.

Top module: `exti_trigger_top`

## Requirements
- R1: After reset every mode field holds code 3 (falling edge), so configuration bytes 0 and 1 both read 0xFF, and `set_req_o` is all zero.
- R2: Mode codes are 0 = active-low level, 1 = active-high level, 2 = rising edge, 3 = falling edge. Byte 0 holds pins 0 to 3 (groups 23 to 26), byte 1 holds pins 4 to 7 (groups 27 to 30); pin k of a byte sits in bits [2k+1:2k]. A write replaces all four fields of the addressed byte, and a read returns the packed codes.
- R3: Addresses 2 and above read as 0x00 and a write to them changes no mode field.
- R4: In active-high mode, `set_req_o[p]` is high in every cycle whose evaluated input sample is 1; a low input never clears or changes anything else.
- R5: In active-low mode, `set_req_o[p]` is high in every cycle whose evaluated input sample is 0.
- R6: In rising mode, a 0-to-1 change of the pin gives exactly one cycle of `set_req_o[p]`; a 1-to-0 change gives none.
- R7: In falling mode, a 1-to-0 change of the pin gives exactly one cycle of `set_req_o[p]`; a 0-to-1 change gives none.
- R8: A pin value first sampled at rising clock edge n is evaluated, as current sample, in the cycle after edge n+1, and the resulting pulse is visible after edge n+2 (two synchronizer flops plus the output register).
- R9: No pulse appears on any pin during the first three clock edges after reset release, whatever the pin levels.
- R10: In the cycle after a write to a pin's byte (while that pin is running), edge modes produce no pulse for that pin; level modes are evaluated with the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 8 | Raw external interrupt pins, asynchronous |
| cfg_wr_en_i | input | 1 | Write strobe for the mode registers |
| cfg_addr_i | input | 4 | Register byte address |
| cfg_wdata_i | input | 8 | Write data (four packed 2-bit modes) |
| cfg_rdata_o | output | 8 | Read data for `cfg_addr_i`, combinational |
| set_req_o | output | 8 | One-cycle set-request pulses, bit p for group 23+p |

## Verification
Each of the four modes is driven with random pin toggles, one mode across all pins at a time and then a mixed byte, so that level modes are told apart from edge modes by repeated versus single pulses and the two polarities and two edge directions are told apart by which transitions fire. Random mode writes are interleaved with pin activity so that edges landing in the settle cycle separate correct muting from a lost or extra pulse. Directed register accesses separate the byte packing and field order, and out-of-range addresses show whether stray writes leak into the mode bytes.

// File: rtl/exti_pkg.sv
package exti_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        TRIG_LEVEL_LOW  = 2'd0,
        TRIG_LEVEL_HIGH = 2'd1,
        TRIG_EDGE_RISE  = 2'd2,
        TRIG_EDGE_FALL  = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        PIN_WARMUP = 2'd0,
        PIN_RUN    = 2'd1,
        PIN_SETTLE = 2'd2
    } pin_state_e;

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/exti_mode_regs.sv
module exti_mode_regs
    import exti_pkg::*;
#(
    parameter int NUM_BYTES     = 2,
    parameter int PINS_PER_BYTE = 4,
    parameter int ADDR_W        = 4,
    localparam int BYTE_W       = PINS_PER_BYTE * MODE_W,
    localparam int NUM_PINS     = NUM_BYTES * PINS_PER_BYTE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    output logic [BYTE_W-1:0]    rdata_o,
    output trig_mode_e           mode_o [NUM_PINS],
    output logic [NUM_BYTES-1:0] byte_wr_o
);

    localparam logic [BYTE_W-1:0] RESET_BYTE = {PINS_PER_BYTE{TRIG_EDGE_FALL}};

    logic [NUM_BYTES*BYTE_W-1:0] regs_q;

    generate
        for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
            assign byte_wr_o[b] = wr_en_i && (addr_i == ADDR_W'(b));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[b*BYTE_W +: BYTE_W] <= RESET_BYTE;
                end else if (byte_wr_o[b]) begin
                    regs_q[b*BYTE_W +: BYTE_W] <= wdata_i;
                end
            end

            for (genvar k = 0; k < PINS_PER_BYTE; k++) begin : g_field
                assign mode_o[b*PINS_PER_BYTE + k] =
                    trig_mode_e'(regs_q[b*BYTE_W + k*MODE_W +: MODE_W]);
            end
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (addr_i == ADDR_W'(b)) begin
                rdata_o = regs_q[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // R3: a write outside the implemented bytes leaves every field alone
    assert_oob_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i >= ADDR_W'(NUM_BYTES)) |=> $stable(regs_q));

    // R2: a write to byte 0 is visible at the read port of byte 0 afterwards
    assert_byte0_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == '0) |=> (regs_q[BYTE_W-1:0] == $past(wdata_i)));

endmodule

// File: rtl/exti_pin_cond.sv
module exti_pin_cond
    import exti_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(SYNC_STAGES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  trig_mode_e mode_i,
    input  logic       mode_wr_i,
    output logic       set_req_o
);

    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(SYNC_STAGES);

    pin_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             prev_q;
    logic             fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= PIN_WARMUP;
            cnt_q     <= '0;
            prev_q    <= 1'b0;
            set_req_o <= 1'b0;
        end else begin
            state_q   <= state_d;
            prev_q    <= sync_i;
            set_req_o <= fire;
            if (state_q == PIN_WARMUP && cnt_q != WARM_LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_WARMUP: if (cnt_q == WARM_LAST) state_d = PIN_RUN;
            PIN_RUN:    if (mode_wr_i)          state_d = PIN_SETTLE;
            PIN_SETTLE: state_d = mode_wr_i ? PIN_SETTLE : PIN_RUN;
            default:    state_d = PIN_WARMUP;
        endcase
    end

    // output logic
    always_comb begin
        fire = 1'b0;
        if (state_q != PIN_WARMUP) begin
            unique case (mode_i)
                TRIG_LEVEL_LOW:  fire = !sync_i;
                TRIG_LEVEL_HIGH: fire = sync_i;
                TRIG_EDGE_RISE:  fire = (state_q == PIN_RUN) && sync_i && !prev_q;
                TRIG_EDGE_FALL:  fire = (state_q == PIN_RUN) && !sync_i && prev_q;
                default:         fire = 1'b0;
            endcase
        end
    end

    // R9: nothing leaves the block while the pipeline is still filling
    assert_warmup_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_WARMUP) |=> !set_req_o);

    // R10: edge modes are muted during the settle cycle
    assert_settle_mutes_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_SETTLE && (mode_i == TRIG_EDGE_RISE || mode_i == TRIG_EDGE_FALL))
        |=> !set_req_o);

    // R4: a high sample in active-high mode always requests
    assert_level_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PIN_WARMUP && mode_i == TRIG_LEVEL_HIGH && sync_i) |=> set_req_o);

    // R6: a rising-edge pulse lasts a single cycle
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req_o && mode_i == TRIG_EDGE_RISE) |=> (!set_req_o || mode_i != TRIG_EDGE_RISE));

endmodule

// File: rtl/exti_trigger_top.sv
module exti_trigger_top
    import exti_pkg::*;
#(
    parameter int NUM_BYTES     = 2,
    parameter int PINS_PER_BYTE = 4,
    parameter int ADDR_W        = 4,
    parameter int SYNC_STAGES   = 2,
    localparam int NUM_PINS     = NUM_BYTES * PINS_PER_BYTE,
    localparam int BYTE_W       = PINS_PER_BYTE * MODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] ext_pin_i,
    input  logic                cfg_wr_en_i,
    input  logic [ADDR_W-1:0]   cfg_addr_i,
    input  logic [BYTE_W-1:0]   cfg_wdata_i,
    output logic [BYTE_W-1:0]   cfg_rdata_o,
    output logic [NUM_PINS-1:0] set_req_o
);

    trig_mode_e           pin_mode [NUM_PINS];
    logic [NUM_BYTES-1:0] byte_wr;
    logic [NUM_PINS-1:0]  pin_sync;

    exti_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_pin_i),
        .sync_o  (pin_sync)
    );

    exti_mode_regs #(
        .NUM_BYTES     (NUM_BYTES),
        .PINS_PER_BYTE (PINS_PER_BYTE),
        .ADDR_W        (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_wr_en_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .rdata_o   (cfg_rdata_o),
        .mode_o    (pin_mode),
        .byte_wr_o (byte_wr)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            exti_pin_cond #(
                .SYNC_STAGES (SYNC_STAGES)
            ) cond_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .sync_i    (pin_sync[p]),
                .mode_i    (pin_mode[p]),
                .mode_wr_i (byte_wr[p / PINS_PER_BYTE]),
                .set_req_o (set_req_o[p])
            );
        end
    endgenerate

endmodule

// File: tb/exti_trigger_top_tb_top.sv
module exti_trigger_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ext_pin = 8'h00;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] set_req;

    int n_total = 0;
    int n_fail  = 0;
    bit chk_en  = 1'b0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    exti_trigger_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_pin_i   (ext_pin),
        .cfg_wr_en_i (wr_en),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .set_req_o   (set_req)
    );

    // ---------------- reference model built from the requirements ----------------
    bit [7:0] s1, s2, s3;
    bit [1:0] md [8];
    bit [7:0] settle;
    bit [7:0] exp_v;
    string    tag [8];
    int       cyc;

    function automatic bit exp_fire(bit [1:0] m, bit cur, bit old, bit st);
        case (m)
            2'd0:    return !cur;
            2'd1:    return cur;
            2'd2:    return !st && cur && !old;
            default: return !st && !cur && old;
        endcase
    endfunction

    function automatic string mode_tag(bit [1:0] m, bit st, bit run);
        if (!run) return "R9";
        if (st && m[1]) return "R10";
        case (m)
            2'd0:    return "R5";
            2'd1:    return "R4";
            2'd2:    return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            s1 = '0; s2 = '0; s3 = '0; settle = '0; exp_v = '0; cyc = 0;
            for (int k = 0; k < 8; k++) begin md[k] = 2'd3; tag[k] = "R1"; end
        end else begin
            automatic bit run = (cyc >= 3);
            for (int k = 0; k < 8; k++) begin
                exp_v[k] = run ? exp_fire(md[k], s2[k], s3[k], settle[k]) : 1'b0;
                tag[k]   = mode_tag(md[k], settle[k], run);
            end
            s3 = s2; s2 = s1; s1 = ext_pin;
            settle = '0;
            if (wr_en && addr < 4'd2) begin
                for (int k = 0; k < 4; k++) begin
                    md[addr*4 + k]     = wdata[2*k +: 2];
                    settle[addr*4 + k] = run;
                end
            end
            cyc++;
        end
    end

    // per-cycle comparison of the pulse outputs (R8 latency is built into the model)
    always @(negedge clk) begin
        if (rst_n && chk_en && !done) begin
            for (int k = 0; k < 8; k++) begin
                n_total++;
                if (set_req[k] !== exp_v[k]) begin
                    n_fail++;
                    $display("FAIL %s/R8 pin %0d set_req=%0b expected %0b at cycle %0d",
                             tag[k], k, set_req[k], exp_v[k], cyc);
                end
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic check_val(string req, logic [7:0] act, logic [7:0] expv);
        n_total++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, expv);
        end
    endtask

    task automatic cfg_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg_read_check(string req, logic [3:0] a, logic [7:0] expv);
        @(negedge clk);
        addr = a;
        #1;
        check_val(req, rdata, expv);
    endtask

    // random pin activity, optional random mode writes
    task automatic random_pins(int cycles, int toggle_pct, bit with_writes);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            for (int k = 0; k < 8; k++) begin
                if (($urandom % 100) < toggle_pct) ext_pin[k] = ~ext_pin[k];
            end
            wr_en = 1'b0;
            if (with_writes && ($urandom % 16) == 0) begin
                wr_en = 1'b1;
                addr  = 4'($urandom % 3);
                wdata = 8'($urandom);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd1234));
        ext_pin = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_val("R1", set_req, 8'h00);
        addr = 4'd0; #1; check_val("R1", rdata, 8'hFF);
        addr = 4'd1; #1; check_val("R1", rdata, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;
        // R9: pins toggle wildly straight after reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ext_pin = ~ext_pin;
        end
        cfg_read_check("R1", 4'd0, 8'hFF);

        // R2: packing and field order
        cfg_write(4'd0, 8'h1B);
        cfg_write(4'd1, 8'hE4);
        cfg_read_check("R2", 4'd0, 8'h1B);
        cfg_read_check("R2", 4'd1, 8'hE4);
        random_pins(60, 30, 1'b0);

        // R3: out-of-range accesses
        cfg_write(4'd2, 8'h00);
        cfg_write(4'd15, 8'h55);
        cfg_read_check("R3", 4'd0, 8'h1B);
        cfg_read_check("R3", 4'd1, 8'hE4);
        cfg_read_check("R3", 4'd2, 8'h00);
        cfg_read_check("R3", 4'd15, 8'h00);

        // one mode across all pins at a time
        cfg_write(4'd0, 8'hAA); cfg_write(4'd1, 8'hAA);   // R6 rising
        random_pins(150, 25, 1'b0);
        cfg_write(4'd0, 8'hFF); cfg_write(4'd1, 8'hFF);   // R7 falling
        random_pins(150, 25, 1'b0);
        cfg_write(4'd0, 8'h55); cfg_write(4'd1, 8'h55);   // R4 active high
        random_pins(150, 20, 1'b0);
        cfg_write(4'd0, 8'h00); cfg_write(4'd1, 8'h00);   // R5 active low
        random_pins(150, 20, 1'b0);

        // R10: directed edge in the cycle after a write
        cfg_write(4'd0, 8'hAA);
        ext_pin[0] = 1'b0;
        random_pins(6, 0, 1'b0);
        @(negedge clk);
        ext_pin[0] = 1'b1;           // seen as current sample two edges later
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd0; wdata = 8'hAA;
        @(negedge clk);
        wr_en = 1'b0;
        random_pins(6, 0, 1'b0);

        // mixed modes with random writes
        cfg_write(4'd0, 8'h1B); cfg_write(4'd1, 8'hB1);
        random_pins(1500, 30, 1'b1);
        random_pins(10, 0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule